// File: doc/BRIEF.md
# Segmented memory protection checker

This block guards memory accesses without translating them. A foreground map holds a small set of programmable segments. Each segment has an aligned start address, a 13-bit attribute and an enable bit. A segment covers the addresses from its own start up to the start of the next segment by index. The last segment reaches to the top of the address space. A fixed background map, set by parameters, supplies the attribute when no foreground segment applies. That happens when no segment matches, or when the single matching segment is disabled.

The check port takes an address, an access kind and a privilege ring. In the same cycle it returns either a grant or a fault code. A granted access passes the address through unchanged as the physical address. Segment entries are written through a register write port and read back by index. The enable bits also form their own register. A probe port reports which map, which segment and which attribute apply to any address.

Top module: `seg_guard`

## Requirements
- R1: After synchronous reset every foreground start address, attribute and enable bit is zero, so `en_rdata` reads 0 and every in-range read-back returns 0.
- R2: A segment write takes the segment index from `wr_attr_word[4:0]`. It stores the start as `wr_addr_word` rounded down to a multiple of 2^ALIGN_LG2, the attribute as `wr_attr_word[20:8]`, and the enable bit as `wr_addr_word[0]`. Read-back returns `{start | enable}` on `rd_start_word` and `{attribute, 8'h00}` (zero-extended) on `rd_attr_word`. An index at or above NSEG reads back as 0.
- R3: A segment write whose index is at or above NSEG changes no start address, attribute or enable bit.
- R4: An enable-register write keeps only `en_wdata[NSEG-1:0]`. When a segment write lands in the same cycle, that segment's bit takes the value from the segment write.
- R5: Segment i matches address A when A >= start[i] and either i = NSEG-1 or A < start[i+1]. When exactly one segment matches and its enable bit is 1, that segment's attribute is used.
- R6: When no segment matches, or the single matching segment is disabled, the attribute comes from the background entry with the highest index whose start is <= A.
- R7: When two or more segments match, the access is refused. The fault code is 2 for a fetch and 1 otherwise, whatever the attributes say.
- R8: Rights are taken from attribute bits 3:0, which are bits 11:8 of the written word. For ring 0 they are: codes 0-3 none; 4 R; 5 RX; 6 RW; 7 RWX; 8 W; 9 RW; 10 RW; 11 RWX; 12 R; 13 RX; 14 RW; 15 RWX.
- R9: For rings 1-3 the rights are: codes 0-7 none; 8 W; 9 RWX; 10 R; 11 RX; 12 R; 13 RX; 14 RW; 15 RWX.
- R10: Access kind encoding is 0 load, 1 store and 2 fetch; 3 is handled as a load. A load needs R, a store needs W and a fetch needs X. A refused access faults with code 3 (load), 4 (store) or 5 (fetch).
- R11: A granted access gives fault code 0 and `chk_paddr` equal to `chk_addr`. A refused access gives `chk_grant` 0 and `chk_paddr` 0.
- R12: A probe that resolves to an enabled foreground segment returns bit 31 set, the attribute in bits 20:8 and the segment index in bits 4:0. A probe that falls back returns bit 30 set and the background attribute in bits 20:8. A multi-hit probe sets `prb_multi` and returns 0. All other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Segment write strobe |
| wr_addr_word | input | 32 | Start address; bit 0 is the enable |
| wr_attr_word | input | 32 | Attribute in 20:8, segment index in 4:0 |
| en_wr | input | 1 | Enable-register write strobe |
| en_wdata | input | 32 | Enable-register write data |
| en_rdata | output | 32 | Enable register, zero-extended |
| rd_idx | input | 5 | Read-back segment index |
| rd_start_word | output | 32 | Start address OR enable bit |
| rd_attr_word | output | 32 | Attribute shifted to bits 20:8 |
| prb_addr | input | 32 | Probe address |
| prb_result | output | 32 | Probe result word |
| prb_multi | output | 1 | Probe address matches several segments |
| chk_addr | input | 32 | Checked address |
| chk_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 as load |
| chk_ring | input | 2 | Privilege ring, 0 most privileged |
| chk_grant | output | 1 | Access allowed |
| chk_fault | output | 3 | 0 none, 1/2 multi-hit, 3/4/5 denied |
| chk_paddr | output | 32 | Physical address when granted |

## Verification
The bench builds the block with four foreground segments, 4 KiB alignment and the default four-entry background map. With only four segments, indices 4 to 31 in the 5-bit index field are out of range, so ignored writes are easy to reach. Layouts that are not sorted by index can also be built directly to give overlaps and multi-hit faults. Every one of the sixteen rights codes is swept at ring 0 and ring 2 for all four access kinds. A random phase mixes writes, enable updates and unsorted layouts.

// File: rtl/seg_guard_pkg.sv
package seg_guard_pkg;

    localparam int ADDR_W = 32;
    localparam int ATTR_W = 13;
    localparam int IDX_W  = 5;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [2:0] {
        FLT_NONE     = 3'd0,
        FLT_MULTI_LS = 3'd1,
        FLT_MULTI_IF = 3'd2,
        FLT_LOAD     = 3'd3,
        FLT_STORE    = 3'd4,
        FLT_FETCH    = 3'd5
    } fault_e;

    typedef struct packed {
        logic r;
        logic w;
        logic x;
    } rights_t;

    typedef struct packed {
        logic              multi;
        logic              fg_used;
        logic [IDX_W-1:0]  idx;
        logic [ATTR_W-1:0] attr;
    } resolve_t;

    // Rights for a 4-bit code; user is set for any ring other than 0.
    function automatic rights_t decode_rights(input logic [3:0] code, input logic user);
        rights_t rt;
        rt = '0;
        case (code)
            4'd4, 4'd5, 4'd6, 4'd7: if (!user) rt = '{r: 1'b1, w: code[1], x: code[0]};
            4'd8:  rt = '{r: 1'b0, w: 1'b1, x: 1'b0};
            4'd9:  rt = user ? '{r: 1'b1, w: 1'b1, x: 1'b1} : '{r: 1'b1, w: 1'b1, x: 1'b0};
            4'd10: rt = user ? '{r: 1'b1, w: 1'b0, x: 1'b0} : '{r: 1'b1, w: 1'b1, x: 1'b0};
            4'd11: rt = user ? '{r: 1'b1, w: 1'b0, x: 1'b1} : '{r: 1'b1, w: 1'b1, x: 1'b1};
            4'd12, 4'd13, 4'd14, 4'd15: rt = '{r: 1'b1, w: code[1], x: code[0]};
            default: rt = '0;
        endcase
        return rt;
    endfunction

endpackage

// File: rtl/seg_match.sv
module seg_match #(
    parameter int NSEG = 8
) (
    input  logic [NSEG-1:0][31:0] starts,
    input  logic [31:0]           addr,
    output logic [NSEG-1:0]       hit
);
    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        if (g == NSEG - 1) begin : g_last
            assign hit[g] = (addr >= starts[g]);
        end else begin : g_mid
            assign hit[g] = (addr >= starts[g]) && (addr < starts[g+1]);
        end
    end
endmodule

// File: rtl/bg_select.sv
module bg_select #(
    parameter int                   NBG      = 4,
    parameter logic [NBG-1:0][31:0] BG_START = '0,
    parameter logic [NBG-1:0][12:0] BG_ATTR  = '0
) (
    input  logic [31:0] addr,
    output logic [12:0] attr
);
    localparam int BG_W = (NBG > 1) ? $clog2(NBG) : 1;

    logic [BG_W-1:0] sel;

    // Starts are non-decreasing: the last entry at or below addr wins.
    always_comb begin
        sel = '0;
        for (int i = 0; i < NBG; i++) begin
            if (addr >= BG_START[i]) sel = BG_W'(i);
        end
    end

    assign attr = BG_ATTR[sel];
endmodule

// File: rtl/seg_resolve.sv
module seg_resolve
    import seg_guard_pkg::*;
#(
    parameter int                   NSEG     = 8,
    parameter int                   NBG      = 4,
    parameter logic [NBG-1:0][31:0] BG_START = '0,
    parameter logic [NBG-1:0][12:0] BG_ATTR  = '0
) (
    input  logic [NSEG-1:0][31:0]       starts,
    input  logic [NSEG-1:0][ATTR_W-1:0] attrs,
    input  logic [NSEG-1:0]             en,
    input  logic [31:0]                 addr,
    output resolve_t                    res
);
    localparam int SEL_W = (NSEG > 1) ? $clog2(NSEG) : 1;

    logic [NSEG-1:0]   hit;
    logic [ATTR_W-1:0] bg_attr;
    logic [IDX_W-1:0]  idx;
    logic [5:0]        cnt;
    logic [SEL_W-1:0]  sel;

    seg_match #(.NSEG(NSEG)) u_match (
        .starts (starts),
        .addr   (addr),
        .hit    (hit)
    );

    bg_select #(.NBG(NBG), .BG_START(BG_START), .BG_ATTR(BG_ATTR)) u_bg (
        .addr (addr),
        .attr (bg_attr)
    );

    always_comb begin
        idx = '0;
        cnt = '0;
        for (int i = 0; i < NSEG; i++) begin
            if (hit[i]) begin
                idx = IDX_W'(i);
                cnt = cnt + 6'd1;
            end
        end
    end

    assign sel         = idx[SEL_W-1:0];
    assign res.multi   = (cnt > 6'd1);
    assign res.fg_used = (cnt == 6'd1) && en[sel];
    assign res.idx     = idx;
    assign res.attr    = res.fg_used ? attrs[sel] : bg_attr;
endmodule

// File: rtl/seg_guard.sv
module seg_guard
    import seg_guard_pkg::*;
#(
    parameter int                   NSEG      = 8,
    parameter int                   ALIGN_LG2 = 12,
    parameter int                   NBG       = 4,
    parameter logic [NBG-1:0][31:0] BG_START  = {32'hC000_0000, 32'h8000_0000,
                                                 32'h4000_0000, 32'h0000_0000},
    parameter logic [NBG-1:0][12:0] BG_ATTR   = {13'h0009, 13'h000C,
                                                 13'h000F, 13'h0004}
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_addr_word,
    input  logic [31:0] wr_attr_word,
    input  logic        en_wr,
    input  logic [31:0] en_wdata,
    output logic [31:0] en_rdata,
    input  logic [4:0]  rd_idx,
    output logic [31:0] rd_start_word,
    output logic [31:0] rd_attr_word,
    input  logic [31:0] prb_addr,
    output logic [31:0] prb_result,
    output logic        prb_multi,
    input  logic [31:0] chk_addr,
    input  logic [1:0]  chk_kind,
    input  logic [1:0]  chk_ring,
    output logic        chk_grant,
    output logic [2:0]  chk_fault,
    output logic [31:0] chk_paddr
);
    localparam int          SEL_W      = (NSEG > 1) ? $clog2(NSEG) : 1;
    localparam logic [31:0] ALIGN_MASK = ~((32'd1 << ALIGN_LG2) - 32'd1);

    logic [NSEG-1:0][31:0]       start_q;
    logic [NSEG-1:0][ATTR_W-1:0] attr_q;
    logic [NSEG-1:0]             en_q;
    logic [NSEG-1:0]             en_next;

    logic [IDX_W-1:0] wr_idx;
    logic [SEL_W-1:0] wr_sel;
    logic [SEL_W-1:0] rd_sel;
    logic             wr_hit;
    logic             rd_ok;

    assign wr_idx = wr_attr_word[IDX_W-1:0];
    assign wr_sel = wr_idx[SEL_W-1:0];
    assign rd_sel = rd_idx[SEL_W-1:0];
    assign wr_hit = wr_en && ({27'd0, wr_idx} < 32'(NSEG));
    assign rd_ok  = ({27'd0, rd_idx} < 32'(NSEG));

    // Enable register update; a segment write owns its own bit.
    always_comb begin
        en_next = en_q;
        if (en_wr)  en_next = en_wdata[NSEG-1:0];
        if (wr_hit) en_next[wr_sel] = wr_addr_word[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            attr_q  <= '0;
            en_q    <= '0;
        end else begin
            en_q <= en_next;
            if (wr_hit) begin
                start_q[wr_sel] <= wr_addr_word & ALIGN_MASK;
                attr_q[wr_sel]  <= wr_attr_word[20:8];
            end
        end
    end

    assign en_rdata      = 32'(en_q);
    assign rd_start_word = rd_ok ? (start_q[rd_sel] | {31'd0, en_q[rd_sel]}) : 32'd0;
    assign rd_attr_word  = rd_ok ? {11'd0, attr_q[rd_sel], 8'd0} : 32'd0;

    // Probe path
    resolve_t res_prb;
    seg_resolve #(.NSEG(NSEG), .NBG(NBG), .BG_START(BG_START), .BG_ATTR(BG_ATTR)) u_prb (
        .starts (start_q),
        .attrs  (attr_q),
        .en     (en_q),
        .addr   (prb_addr),
        .res    (res_prb)
    );

    assign prb_multi  = res_prb.multi;
    assign prb_result = res_prb.multi   ? 32'd0 :
                        res_prb.fg_used ? {1'b1, 10'd0, res_prb.attr, 3'd0, res_prb.idx} :
                                          {1'b0, 1'b1, 9'd0, res_prb.attr, 8'd0};

    // Check path
    resolve_t  res_chk;
    rights_t   rights;
    acc_kind_e kind;
    fault_e    fault;
    logic      allowed;

    seg_resolve #(.NSEG(NSEG), .NBG(NBG), .BG_START(BG_START), .BG_ATTR(BG_ATTR)) u_chk (
        .starts (start_q),
        .attrs  (attr_q),
        .en     (en_q),
        .addr   (chk_addr),
        .res    (res_chk)
    );

    assign kind   = acc_kind_e'(chk_kind);
    assign rights = decode_rights(res_chk.attr[3:0], chk_ring != 2'd0);

    always_comb begin
        case (kind)
            ACC_STORE: allowed = rights.w;
            ACC_FETCH: allowed = rights.x;
            default:   allowed = rights.r;
        endcase
        if (res_chk.multi) begin
            fault = (kind == ACC_FETCH) ? FLT_MULTI_IF : FLT_MULTI_LS;
        end else if (!allowed) begin
            case (kind)
                ACC_STORE: fault = FLT_STORE;
                ACC_FETCH: fault = FLT_FETCH;
                default:   fault = FLT_LOAD;
            endcase
        end else begin
            fault = FLT_NONE;
        end
    end

    assign chk_fault = fault;
    assign chk_grant = (fault == FLT_NONE);
    assign chk_paddr = chk_grant ? chk_addr : 32'd0;

    logic unused_bits;
    assign unused_bits = ^{wr_attr_word[31:21], wr_attr_word[7:5],
                           res_chk.idx, res_chk.fg_used, res_chk.attr[12:4]};

    if (NSEG < 32) begin : g_en_hi
        logic unused_en_hi;
        assign unused_en_hi = ^en_wdata[31:NSEG];
    end
endmodule

// File: rtl/seg_guard_chk.sv
module seg_guard_chk #(
    parameter int NSEG = 8
) (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [31:0] wr_attr_word,
    input logic        en_wr,
    input logic [31:0] en_rdata,
    input logic [31:0] prb_result,
    input logic        prb_multi,
    input logic [31:0] chk_addr,
    input logic [1:0]  chk_kind,
    input logic        chk_grant,
    input logic [2:0]  chk_fault,
    input logic [31:0] chk_paddr
);
    a_r1_reset_clear: assert property (@(posedge clk) $fell(rst) |-> en_rdata == 32'd0);

    a_r3_ignored_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !en_wr && ({27'd0, wr_attr_word[4:0]} >= 32'(NSEG))) |=> $stable(en_rdata));

    a_r4_enable_width: assert property (@(posedge clk) disable iff (rst)
        (64'(en_rdata) >> NSEG) == 64'd0);

    a_r7_multi_no_grant: assert property (@(posedge clk) disable iff (rst)
        (chk_fault == 3'd1 || chk_fault == 3'd2) |-> !chk_grant);

    a_r7_multi_kind: assert property (@(posedge clk) disable iff (rst)
        chk_fault == 3'd2 |-> chk_kind == 2'd2);

    a_r10_store_fault_kind: assert property (@(posedge clk) disable iff (rst)
        chk_fault == 3'd4 |-> chk_kind == 2'd1);

    a_r11_grant_passthru: assert property (@(posedge clk) disable iff (rst)
        chk_grant |-> (chk_paddr == chk_addr && chk_fault == 3'd0));

    a_r12_probe_map_flags: assert property (@(posedge clk) disable iff (rst)
        !(prb_result[31] && prb_result[30]));

    a_r12_probe_multi_zero: assert property (@(posedge clk) disable iff (rst)
        prb_multi |-> prb_result == 32'd0);
endmodule

bind seg_guard seg_guard_chk #(.NSEG(NSEG)) u_sva (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_attr_word (wr_attr_word),
    .en_wr        (en_wr),
    .en_rdata     (en_rdata),
    .prb_result   (prb_result),
    .prb_multi    (prb_multi),
    .chk_addr     (chk_addr),
    .chk_kind     (chk_kind),
    .chk_grant    (chk_grant),
    .chk_fault    (chk_fault),
    .chk_paddr    (chk_paddr)
);

// File: tb/seg_guard_test.sv
module seg_guard_test;
    localparam int NS = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_addr_word = '0;
    logic [31:0] wr_attr_word = '0;
    logic        en_wr = 1'b0;
    logic [31:0] en_wdata = '0;
    logic [31:0] en_rdata;
    logic [4:0]  rd_idx = '0;
    logic [31:0] rd_start_word;
    logic [31:0] rd_attr_word;
    logic [31:0] prb_addr = '0;
    logic [31:0] prb_result;
    logic        prb_multi;
    logic [31:0] chk_addr = '0;
    logic [1:0]  chk_kind = '0;
    logic [1:0]  chk_ring = '0;
    logic        chk_grant;
    logic [2:0]  chk_fault;
    logic [31:0] chk_paddr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    seg_guard #(.NSEG(NS), .ALIGN_LG2(12)) uut (.*);

    // Behavioural model state
    logic [31:0] ms [NS];
    logic [12:0] ma [NS];
    logic [NS-1:0] me;
    logic [31:0] bg_s [4] = '{32'h0000_0000, 32'h4000_0000, 32'h8000_0000, 32'hC000_0000};
    logic [12:0] bg_a [4] = '{13'h0004, 13'h000F, 13'h000C, 13'h0009};

    function automatic logic [2:0] exp_rwx(input int code, input int ring);
        if (code < 4) return 3'b000;
        if (code < 8) return (ring == 0) ? {1'b1, code[1], code[0]} : 3'b000;
        if (code >= 12) return {1'b1, code[1], code[0]};
        if (code == 8) return 3'b010;
        if (code == 9) return (ring == 0) ? 3'b110 : 3'b111;
        if (code == 10) return (ring == 0) ? 3'b110 : 3'b100;
        return (ring == 0) ? 3'b111 : 3'b101;
    endfunction

    // Returns attribute in use; sets hits/idx/fg
    function automatic logic [12:0] lookup(input logic [31:0] a, output int hits,
                                           output int idx, output bit fg);
        int b;
        hits = 0; idx = 0; fg = 0;
        for (int i = 0; i < NS; i++) begin
            if (a >= ms[i] && (i == NS - 1 || a < ms[i+1])) begin
                hits++;
                idx = i;
            end
        end
        if (hits == 1 && me[idx]) begin
            fg = 1;
            return ma[idx];
        end
        b = 0;
        for (int i = 0; i < 4; i++) if (a >= bg_s[i]) b = i;
        return bg_a[b];
    endfunction

    task automatic cmp(input string req, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s [%s] actual %h expected %h", req, tag, act, exp);
        end
    endtask

    task automatic tick(input string tag);
        int hits, idx, code;
        bit fg;
        logic [12:0] at;
        logic [2:0] rwx;
        logic ok;
        logic [31:0] e_prb, e_fault, e_start, e_attr;
        #1;
        // probe
        at = lookup(prb_addr, hits, idx, fg);
        if (hits > 1) e_prb = 0;
        else if (fg) e_prb = 32'h8000_0000 | (32'(at) << 8) | 32'(idx);
        else e_prb = 32'h4000_0000 | (32'(at) << 8);
        cmp("R12", tag, prb_result, e_prb);
        cmp("R12", tag, {31'd0, prb_multi}, {31'd0, hits > 1});
        // check
        at = lookup(chk_addr, hits, idx, fg);
        code = int'(at[3:0]);
        rwx = exp_rwx(code, int'(chk_ring));
        ok = (chk_kind == 1) ? rwx[1] : (chk_kind == 2) ? rwx[0] : rwx[2];
        if (hits > 1) e_fault = (chk_kind == 2) ? 2 : 1;
        else if (!ok) e_fault = (chk_kind == 1) ? 4 : (chk_kind == 2) ? 5 : 3;
        else e_fault = 0;
        cmp("R10", tag, {29'd0, chk_fault}, e_fault);
        cmp("R11", tag, {31'd0, chk_grant}, {31'd0, e_fault == 0});
        cmp("R11", tag, chk_paddr, (e_fault == 0) ? chk_addr : 32'd0);
        // read-back
        if (rd_idx < NS) begin
            e_start = ms[rd_idx] | {31'd0, me[rd_idx]};
            e_attr = {11'd0, ma[rd_idx], 8'd0};
        end else begin
            e_start = 0;
            e_attr = 0;
        end
        cmp("R2", tag, rd_start_word, e_start);
        cmp("R2", tag, rd_attr_word, e_attr);
        cmp("R4", tag, en_rdata, {28'd0, me});
        @(posedge clk);
        if (rst) begin
            for (int i = 0; i < NS; i++) begin ms[i] = 0; ma[i] = 0; end
            me = 0;
        end else begin
            if (en_wr) me = en_wdata[NS-1:0];
            if (wr_en && wr_attr_word[4:0] < NS) begin
                ms[wr_attr_word[4:0]] = wr_addr_word & 32'hFFFF_F000;
                ma[wr_attr_word[4:0]] = wr_attr_word[20:8];
                me[wr_attr_word[4:0]] = wr_addr_word[0];
            end
        end
        @(negedge clk);
    endtask

    task automatic seg_wr(input int idx, input logic [31:0] addr, input logic [12:0] attr, input string tag);
        wr_en = 1;
        wr_addr_word = addr;
        wr_attr_word = {11'h5A5, attr, 3'b111, 5'(idx)};
        rd_idx = 5'(idx);
        tick(tag);
        wr_en = 0;
        tick(tag);
    endtask

    task automatic sweep(input string tag);
        logic [31:0] addrs [10] = '{32'h0, 32'h0100_0000, 32'h1FFF_FFFF, 32'h2000_0000, 32'h5FFF_FFFF,
                                   32'h6000_1234, 32'h9000_0000, 32'hA000_0000, 32'hC800_0000, 32'hFFFF_FFFF};
        for (int a = 0; a < 10; a++) begin
            for (int k = 0; k < 4; k++) begin
                chk_addr = addrs[a];
                prb_addr = addrs[a];
                chk_kind = 2'(k);
                chk_ring = 2'((a + k) % 4);
                rd_idx = 5'((a + k) % 8);
                tick(tag);
            end
        end
    endtask

    initial begin : watchdog
        #1_500_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NS; i++) begin ms[i] = 0; ma[i] = 0; end
        me = 0;
        @(negedge clk);
        tick("R1 reset");
        rst = 0;
        for (int i = 0; i < 8; i++) begin
            rd_idx = 5'(i);
            tick("R1 after reset");
        end
        sweep("R6 background only");

        // R2 / R5 sorted layout
        seg_wr(0, 32'h0000_0001, 13'h000E, "R2 seg0");
        seg_wr(1, 32'h2000_0ABD, 13'h1A05, "R2 seg1 unaligned");
        seg_wr(2, 32'h6000_0FFF & 32'hFFFF_FFFE, 13'h0009, "R2 seg2 disabled");
        seg_wr(3, 32'hA000_0001, 13'h000B, "R2 seg3");
        sweep("R5 R6 R8 R9 sorted");

        // R3 out-of-range writes
        seg_wr(4, 32'h1234_5001, 13'h0FFF, "R3 index 4");
        seg_wr(31, 32'h0000_0000, 13'h0000, "R3 index 31");
        for (int i = 0; i < NS; i++) begin
            rd_idx = 5'(i);
            tick("R3 readback");
        end

        // R4 enable register, masked, with same-cycle segment write override
        en_wr = 1; en_wdata = 32'hFFFF_FFF4;
        tick("R4 mask");
        en_wr = 0;
        tick("R4 mask");
        en_wr = 1; en_wdata = 32'h0000_0005;
        wr_en = 1; wr_addr_word = 32'h2000_0000; wr_attr_word = {11'd0, 13'h0005, 3'd0, 5'd1};
        tick("R4 override");
        en_wr = 0; wr_en = 0;
        tick("R4 override");
        sweep("R4 R6 after enable change");

        // R7 multi-hit: unsorted starts
        seg_wr(2, 32'h1000_0001, 13'h000F, "R7 setup");
        sweep("R7 multi-hit");

        // R8 / R9 all rights codes on seg0 region
        for (int c = 0; c < 16; c++) begin
            seg_wr(0, 32'h0000_0001, 13'(c), "R8 code");
            for (int r = 0; r < 4; r += 2) begin
                for (int k = 0; k < 4; k++) begin
                    chk_addr = 32'h0100_0000; prb_addr = 32'h0100_0000;
                    chk_kind = 2'(k); chk_ring = 2'(r);
                    tick(r == 0 ? "R8 ring0" : "R9 ring2");
                end
            end
        end

        // Random mix
        for (int n = 0; n < 400; n++) begin
            wr_en = ($urandom % 4) == 0;
            wr_addr_word = $urandom;
            wr_attr_word = {11'($urandom), 13'($urandom), 3'($urandom), 5'($urandom % 6)};
            en_wr = ($urandom % 12) == 0;
            en_wdata = $urandom;
            rd_idx = 5'($urandom % 6);
            chk_addr = $urandom; prb_addr = $urandom;
            if (n % 3 == 0) prb_addr = chk_addr;
            chk_kind = 2'($urandom); chk_ring = 2'($urandom);
            tick("R5 R7 R12 random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule